// File: doc/BRIEF.md
# Infrared Carrier Window Demodulator

This block sits between a raw infrared receiver pin and a pulse-width timer. It turns a carrier-modulated input into a clean baseband level: 1 for a mark (carrier present), 0 for a space. The raw pin is first synchronised to the reference clock. The detector then counts prescaler ticks between successive rising edges of the pin. A carrier period is nominally 16 ticks, and one tick lasts D+1 reference clocks as set by an external prescaler. An edge counts as carrier only when its spacing from the previous rising edge lies inside a tolerance window around 16. A two-bit code chooses the window.

A mark begins at the first in-window edge and lasts while in-window edges keep arriving. It ends once no in-window edge has been seen for more ticks than the upper limit of the window. When demodulation is off, the synchronised pin goes straight through. In both modes the level then passes a minimum-width filter. The filter drops any level that lasts fewer reference clocks than a programmable 16-bit count; a count of zero turns the filter off.

Top module: `ir_carrier_demod`

## Requirements
- R1: After reset, `ir_level` is 0 (space).
- R2: With `demod_en` = 0 and `min_width` = 0, `ir_level` follows the pin with a fixed latency of three clocks: two synchroniser stages plus the filter register.
- R3: Edge spacing is counted only on clocks where `tick` is 1. A carrier of 32 clocks is accepted when `tick` is high on every other clock, and rejected when `tick` is high on every clock.
- R4: With `S` the number of ticks between two rising edges, an edge is in-window when `16 - L <= S <= 16 + H`. Here `L` is 4 if `win_sel[0]` is 1 and 3 otherwise, and `H` is 4 if `win_sel[1]` is 1 and 3 otherwise. Both bounds are inclusive.
- R5: The first rising edge after an idle period only serves as a timing reference. A mark starts only at an in-window edge, so a single pulse gives no mark and two pulses 16 ticks apart give one.
- R6: The mark falls to space when more than `16 + H` ticks pass since the last in-window edge. Edges outside the window do not extend the mark.
- R7: With `demod_en` = 1, a steady input level with no further edges yields space.
- R8: With `min_width` = N > 0, a new level reaches `ir_level` only after the filter input has held it for N consecutive clocks. A shorter excursion in either direction is dropped.
- R9: With `min_width` = 0, the filter adds exactly one register stage and rejects nothing. A one-clock pulse appears on `ir_level` for one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_pin | input | 1 | Raw infrared receiver level, asynchronous |
| tick | input | 1 | Prescaler tick, high for one clock per tick period |
| win_sel | input | 2 | Tolerance code: bit 0 widens the lower bound to -4, bit 1 widens the upper bound to +4 |
| demod_en | input | 1 | 1 selects carrier detection, 0 passes the pin through |
| min_width | input | FILT_W | Minimum accepted level width in clocks; 0 disables the filter |
| ir_level | output | 1 | Cleaned baseband level, 1 = mark |

## Verification
Several properties are checked on every cycle: the one-register bypass of the filter, pin-to-output pass-through with demodulation off, that a mark only rises right after a synchronised rising edge, that a filtered output only rises after the filter input has held high, and an upper bound on how long a mark survives without edges. The exact edges of the tolerance window for each code, the role of the tick in measuring spacing, the single-reference-edge rule, and out-of-window edges failing to extend a mark can only be shown by the bench's carrier bursts. Each burst has a chosen period, and its final level is compared against the value the window predicts.

// File: rtl/ir_demod_pkg.sv
package ir_demod_pkg;

    // Nominal carrier period in prescaler ticks and the two tolerance sizes
    localparam int NOM_TICKS = 16;
    localparam int TOL_NARROW = 3;
    localparam int TOL_WIDE = 4;
    // Largest upper bound any window code can produce
    localparam int HI_LIMIT_MAX = NOM_TICKS + TOL_WIDE;

    // Lower accepted spacing: bit 0 of the code widens it
    function automatic int win_low(input logic [1:0] code);
        return NOM_TICKS - (code[0] ? TOL_WIDE : TOL_NARROW);
    endfunction

    // Upper accepted spacing: bit 1 of the code widens it
    function automatic int win_high(input logic [1:0] code);
        return NOM_TICKS + (code[1] ? TOL_WIDE : TOL_NARROW);
    endfunction

endpackage

// File: rtl/ir_demod_sync.sv
module ir_demod_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic rise
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d.chain = pin;
                st_d.prev  = st_q.chain[STAGES-1];
            end
        end else begin : g_chain
            always_comb begin
                st_d.chain = {st_q.chain[STAGES-2:0], pin};
                st_d.prev  = st_q.chain[STAGES-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl  = st_q.chain[STAGES-1];
    assign rise = st_q.chain[STAGES-1] & ~st_q.prev;

endmodule

// File: rtl/ir_carrier_det.sv
module ir_carrier_det
    import ir_demod_pkg::*;
#(
    parameter int GAP_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise,
    input  logic       tick,
    input  logic [1:0] win_sel,
    output logic       mark
);

    localparam int GAP_MAX = (2 ** GAP_W) - 1;
    localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(GAP_MAX);

    typedef struct packed {
        logic [GAP_W-1:0] gap;   // ticks since the last rising edge
        logic [GAP_W-1:0] hold;  // ticks since the last in-window edge
        logic             mark;
    } det_st_t;

    det_st_t st_d, st_q;

    logic [GAP_W-1:0] span;
    logic [GAP_W-1:0] lo_b, hi_b;
    logic             in_win, accept;

    function automatic logic [GAP_W-1:0] sat_inc(input logic [GAP_W-1:0] v,
                                                 input logic inc);
        if (inc && (v != GAP_SAT)) return v + GAP_W'(1);
        return v;
    endfunction

    always_comb begin
        lo_b   = GAP_W'(win_low(win_sel));
        hi_b   = GAP_W'(win_high(win_sel));
        // a tick on the edge cycle still belongs to the closing interval
        span   = sat_inc(st_q.gap, tick);
        in_win = (span >= lo_b) && (span <= hi_b);
        accept = rise && in_win;

        st_d      = st_q;
        st_d.gap  = rise ? '0 : span;
        st_d.hold = accept ? '0 : sat_inc(st_q.hold, tick);
        if (accept)
            st_d.mark = 1'b1;
        else if (st_d.hold > hi_b)
            st_d.mark = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gap  <= GAP_SAT;
            st_q.hold <= GAP_SAT;
            st_q.mark <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mark = st_q.mark;

endmodule

// File: rtl/ir_min_width_filt.sv
module ir_min_width_filt #(
    parameter int FILT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic [FILT_W-1:0] min_cnt,
    output logic              dout
);

    typedef struct packed {
        logic [FILT_W-1:0] run;  // consecutive clocks din differs from output
        logic              out;
    } filt_st_t;

    filt_st_t st_d, st_q;
    logic [FILT_W:0] run_nx;

    always_comb begin
        st_d   = st_q;
        run_nx = {1'b0, st_q.run} + {{FILT_W{1'b0}}, 1'b1};
        if (min_cnt == '0) begin
            st_d.out = din;
            st_d.run = '0;
        end else if (din == st_q.out) begin
            st_d.run = '0;
        end else if (run_nx >= {1'b0, min_cnt}) begin
            st_d.out = din;
            st_d.run = '0;
        end else begin
            st_d.run = run_nx[FILT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.out;

endmodule

// File: rtl/ir_carrier_demod.sv
module ir_carrier_demod #(
    parameter int SYNC_STAGES = 2,
    parameter int GAP_W       = 5,
    parameter int FILT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_pin,
    input  logic              tick,
    input  logic [1:0]        win_sel,
    input  logic              demod_en,
    input  logic [FILT_W-1:0] min_width,
    output logic              ir_level
);

    logic sync_lvl;
    logic sync_rise;
    logic det_mark;
    logic pre;

    ir_demod_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ir_pin),
        .lvl  (sync_lvl),
        .rise (sync_rise)
    );

    ir_carrier_det #(.GAP_W(GAP_W)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise   (sync_rise),
        .tick   (tick),
        .win_sel(win_sel),
        .mark   (det_mark)
    );

    always_comb begin
        pre = demod_en ? det_mark : sync_lvl;
    end

    ir_min_width_filt #(.FILT_W(FILT_W)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (pre),
        .min_cnt(min_width),
        .dout   (ir_level)
    );

endmodule

// File: rtl/ir_demod_checks.sv
module ir_demod_checks
    import ir_demod_pkg::*;
#(
    parameter int GAP_W  = 5,
    parameter int FILT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              rise,
    input logic              sync_lvl,
    input logic              det_mark,
    input logic              pre,
    input logic              demod_en,
    input logic [FILT_W-1:0] min_width,
    input logic              ir_level
);

    localparam int CK_MAX = (2 ** GAP_W) - 1;

    // independent tick count since the last synchronised rising edge
    logic [GAP_W-1:0] ck_gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ck_gap <= GAP_W'(CK_MAX);
        else if (rise)
            ck_gap <= '0;
        else if (tick && (ck_gap != GAP_W'(CK_MAX)))
            ck_gap <= ck_gap + GAP_W'(1);
    end

    // R9: zero count leaves a single register between mux and output
    assert_bypass_one_stage_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (min_width == '0) |=> (ir_level == $past(pre)));

    // R2: pass-through mode ties the output to the synchronised pin
    assert_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!demod_en && (min_width == '0)) |=> (ir_level == $past(sync_lvl)));

    // R5: a mark can only begin right after a rising edge
    assert_mark_needs_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_mark) |-> $past(rise));

    // R8: with a count of two or more, a rise needs two high inputs
    assert_min_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ir_level) && ($past(min_width) >= FILT_W'(2)))
            |-> ($past(pre) && $past(pre, 2)));

    // R6: no mark survives beyond the widest upper bound without an edge
    assert_mark_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        det_mark |-> (ck_gap <= GAP_W'(HI_LIMIT_MAX)));

endmodule

bind ir_carrier_demod ir_demod_checks #(.GAP_W(GAP_W), .FILT_W(FILT_W)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .rise     (sync_rise),
    .sync_lvl (sync_lvl),
    .det_mark (det_mark),
    .pre      (pre),
    .demod_en (demod_en),
    .min_width(min_width),
    .ir_level (ir_level)
);

// File: tb/ir_carrier_demod_test.sv
module ir_carrier_demod_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_pin = 1'b0;
    logic        tick = 1'b1;
    logic [1:0]  win_sel = 2'b00;
    logic        demod_en = 1'b0;
    logic [15:0] min_width = 16'd0;
    logic        ir_level;

    always #4 clk = ~clk;

    ir_carrier_demod uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ir_pin   (ir_pin),
        .tick     (tick),
        .win_sel  (win_sel),
        .demod_en (demod_en),
        .min_width(min_width),
        .ir_level (ir_level)
    );

    typedef struct {
        string tag;
        logic  exp;
    } exp_t;

    exp_t sb[$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    bit   tick_half = 1'b0;
    bit   tick_ph = 1'b0;

    // tick generator: every clock, or every other clock
    initial begin
        forever begin
            @(negedge clk);
            tick_ph = ~tick_ph;
            tick = tick_half ? tick_ph : 1'b1;
        end
    end

    // monitor: compares each queued expectation just after a falling edge
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                it = sb.pop_front();
                n_run++;
                if (ir_level !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: ir_level=%b expected=%b", it.tag, ir_level, it.exp);
                end
            end
        end
    end

    task automatic expect_lvl(input string tag, input logic e);
        exp_t it;
        it.tag = tag;
        it.exp = e;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        ir_pin = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic carrier(input int period, input int pulses);
        for (int j = 0; j < pulses; j++) begin
            for (int i = 0; i < period; i++) begin
                @(negedge clk);
                ir_pin = (i < period / 2);
            end
        end
    endtask

    task automatic win_case(input string tag, input logic [1:0] code,
                            input int period, input logic e);
        win_sel = code;
        carrier(period, 4);
        expect_lvl(tag, e);
        idle(40);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_lvl("R1 reset space", 1'b0);

        // pass-through, no filter
        @(negedge clk);
        ir_pin = 1'b1;
        repeat (5) @(negedge clk);
        expect_lvl("R2 pass high", 1'b1);
        ir_pin = 1'b0;
        repeat (5) @(negedge clk);
        expect_lvl("R2 pass low", 1'b0);

        // one-clock pulse with filter off: visible exactly 3 clocks later
        @(negedge clk); ir_pin = 1'b1;
        @(negedge clk); ir_pin = 1'b0;
        @(negedge clk);
        @(negedge clk); expect_lvl("R9 one-clock pulse shown", 1'b1);
        @(negedge clk); expect_lvl("R9 one-clock pulse ends", 1'b0);

        // minimum width filter
        min_width = 16'd10;
        idle(5);
        ir_pin = 1'b1;
        repeat (9) @(negedge clk);
        ir_pin = 1'b0;
        repeat (4) @(negedge clk);
        expect_lvl("R8 nine-clock pulse rejected", 1'b0);
        repeat (10) @(negedge clk);
        expect_lvl("R8 nine-clock pulse stays rejected", 1'b0);
        ir_pin = 1'b1;
        repeat (10) @(negedge clk);
        ir_pin = 1'b0;
        repeat (4) @(negedge clk);
        expect_lvl("R8 ten-clock pulse accepted", 1'b1);
        repeat (20) @(negedge clk);
        expect_lvl("R8 accepted pulse falls", 1'b0);
        ir_pin = 1'b1;
        repeat (20) @(negedge clk);
        expect_lvl("R8 steady high", 1'b1);
        ir_pin = 1'b0;
        repeat (5) @(negedge clk);
        ir_pin = 1'b1;
        repeat (12) @(negedge clk);
        expect_lvl("R8 low glitch rejected", 1'b1);
        ir_pin = 1'b0;
        repeat (20) @(negedge clk);
        expect_lvl("R8 long low accepted", 1'b0);
        min_width = 16'd0;

        // carrier detection
        demod_en = 1'b1;
        win_sel = 2'b00;
        idle(40);
        carrier(16, 1);
        expect_lvl("R5 single pulse no mark", 1'b0);
        idle(40);
        carrier(16, 2);
        expect_lvl("R5 two pulses start mark", 1'b1);
        idle(40);
        expect_lvl("R6 mark ends after idle", 1'b0);

        carrier(16, 4);
        expect_lvl("R6 burst mark", 1'b1);
        repeat (3) @(negedge clk);
        expect_lvl("R6 mark held inside window", 1'b1);
        repeat (20) @(negedge clk);
        expect_lvl("R6 mark timed out", 1'b0);
        idle(40);

        carrier(16, 3);
        carrier(8, 8);
        expect_lvl("R6 fast edges do not extend", 1'b0);
        idle(40);

        win_case("R4 code00 spacing13 in", 2'b00, 13, 1'b1);
        win_case("R4 code00 spacing12 out", 2'b00, 12, 1'b0);
        win_case("R4 code01 spacing12 in", 2'b01, 12, 1'b1);
        win_case("R4 code00 spacing19 in", 2'b00, 19, 1'b1);
        win_case("R4 code00 spacing20 out", 2'b00, 20, 1'b0);
        win_case("R4 code10 spacing20 in", 2'b10, 20, 1'b1);
        win_case("R4 code10 spacing12 out", 2'b10, 12, 1'b0);
        win_case("R4 code01 spacing20 out", 2'b01, 20, 1'b0);
        win_case("R4 code11 spacing12 in", 2'b11, 12, 1'b1);
        win_case("R4 code11 spacing20 in", 2'b11, 20, 1'b1);

        win_case("R3 32 clocks full tick rate out", 2'b00, 32, 1'b0);
        tick_half = 1'b1;
        win_case("R3 32 clocks half tick rate in", 2'b00, 32, 1'b1);
        tick_half = 1'b0;

        idle(10);
        ir_pin = 1'b1;
        repeat (40) @(negedge clk);
        expect_lvl("R7 steady level gives space", 1'b0);
        ir_pin = 1'b0;

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=not finished expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule